// File: doc/BRIEF.md
# Receive Self-Test Loop Monitor

This block watches the symbol stream arriving at a receiver during built-in self-test. The transmitter sends a fixed pseudo-random sequence of 511 symbols, over and over. The monitor first hunts for the point where a loop begins. It then follows the sequence symbol by symbol and compares each received symbol with the one it expects. A single progress output tells the outside world how the test is going:

- it stays high while the monitor hunts;
- it stays low while the monitor is locked;
- it gives a one-clock pulse each time a loop completes.

If mismatches pile up inside a sliding window of recent symbols, the monitor drops lock and starts hunting again. A sync flag and a live mismatch count are also provided. All three outputs are registered. Each one updates on the clock edge that accepts the symbol causing the change.

Top module: `rx_bist_monitor`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `prog_o`, `sync_o` and `err_cnt_o` are all 0.
- R2: On an edge where `bist_en_i` is low, the monitor goes back to hunting and clears its mismatch window. After that edge, `prog_o` = 0, `sync_o` = 0 and `err_cnt_o` = 0.
- R3: While enabled and hunting, `prog_o` is 1 after every edge.
- R4: The loop start is marked by two consecutive valid symbols that both equal 8'hFF. The second of the pair is loop position 0. On that pair's second valid edge, `sync_o` becomes 1 and `prog_o` becomes 0. A lone 8'hFF followed by any other symbol does not lock.
- R5: The symbol expected at loop position k is the low 8 bits of state k of a 9-bit shift register. State 0 is all ones, and the next state is {s[7:0], s[8]^s[4]}. A locked stream that matches this sequence keeps `sync_o` = 1 and `err_cnt_o` = 0.
- R6: While locked, `prog_o` is 1 for exactly the one clock after the valid edge that accepts loop position 510, and 0 otherwise. Position 510 is followed by position 0.
- R7: While locked, `err_cnt_o` equals the number of mismatching symbols among the last 28 valid symbols.
- R8: Lock is lost on the valid edge where a mismatch brings the count over the last 28 valid symbols, that symbol included, to 14. After that edge, `sync_o` = 0, `prog_o` = 1 and `err_cnt_o` = 0.
- R9: An edge with `sym_vld_i` low does not advance the loop position and does not change the mismatch window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en_i | input | 1 | Self-test enable |
| sym_vld_i | input | 1 | Received symbol is valid this cycle |
| sym_i | input | 8 | Received symbol |
| prog_o | output | 1 | Progress indicator: high while hunting, one-clock pulse at each loop end |
| sync_o | output | 1 | Monitor is locked to the loop |
| err_cnt_o | output | 5 | Mismatches among the last 28 valid symbols |

## Verification
The assertions assume three things about the inputs:
- `bist_en_i` and `sym_vld_i` are known after reset.
- A loop start can only be recognised through the 8'hFF pair.
- The transmitter never produces that pair anywhere except at a loop boundary.

The stimulus keeps to these assumptions. Filler symbols drawn during hunting never contain two 8'hFF values in a row. The only such pair comes from the pattern itself, at position 510 followed by position 0. Corrupted symbols are made by flipping bits of the expected value, so each one is a real mismatch.

// File: rtl/rx_bist_pkg.sv
package rx_bist_pkg;

    localparam int unsigned PRBS_W   = 9;
    localparam int unsigned PRBS_TAP = 5;
    localparam int unsigned SYM_W    = 8;
    localparam int unsigned LOOP_LEN = (1 << PRBS_W) - 1;
    localparam int unsigned POS_W    = PRBS_W;

    localparam logic [PRBS_W-1:0] PRBS_SEED = '1;
    localparam logic [SYM_W-1:0]  MARK_SYM  = '1;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } mon_state_e;

    typedef struct packed {
        logic [PRBS_W-1:0] prbs;
        logic [POS_W-1:0]  pos;
    } loop_ptr_t;

    function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
        return {s[PRBS_W-2:0], s[PRBS_W-1] ^ s[PRBS_TAP-1]};
    endfunction

    function automatic logic [SYM_W-1:0] prbs_sym(input logic [PRBS_W-1:0] s);
        return s[SYM_W-1:0];
    endfunction

endpackage

// File: rtl/rx_bist_loop_ptr.sv
module rx_bist_loop_ptr
    import rx_bist_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    output logic [SYM_W-1:0] exp_sym,
    output logic             at_last
);

    loop_ptr_t ptr;

    assign exp_sym = prbs_sym(ptr.prbs);
    assign at_last = (ptr.pos == POS_W'(LOOP_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '{prbs: PRBS_SEED, pos: '0};
        end else if (load) begin
            // the marker symbol is position 0; the next one expected is position 1
            ptr <= '{prbs: prbs_step(PRBS_SEED), pos: POS_W'(1)};
        end else if (adv) begin
            ptr.prbs <= prbs_step(ptr.prbs);
            ptr.pos  <= at_last ? '0 : ptr.pos + POS_W'(1);
        end
    end

    // R5: position stays inside the loop and the shift register never dies
    p_pos_range_r5: assert property (@(posedge clk) disable iff (rst)
        ptr.pos < POS_W'(LOOP_LEN));
    p_prbs_live_r5: assert property (@(posedge clk) disable iff (rst)
        ptr.prbs != '0);
    // R6: the counter wrap and the sequence wrap coincide
    p_wrap_seed_r6: assert property (@(posedge clk) disable iff (rst)
        (adv && at_last && !load) |=> (ptr.prbs == PRBS_SEED && ptr.pos == '0));

endmodule

// File: rtl/rx_bist_err_window.sv
module rx_bist_err_window #(
    parameter  int WIN_LEN   = 28,
    parameter  int ERR_LIMIT = 14,
    localparam int CNT_W     = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift,
    input  logic             miss,
    output logic [CNT_W-1:0] cnt,
    output logic             trip
);

    logic [WIN_LEN-1:0] win;
    logic [WIN_LEN-1:0] win_nxt;
    logic [CNT_W-1:0]   cnt_nxt;

    assign win_nxt = {win[WIN_LEN-2:0], miss};

    always_comb begin
        cnt     = '0;
        cnt_nxt = '0;
        for (int i = 0; i < WIN_LEN; i++) begin
            cnt     = cnt + CNT_W'(win[i]);
            cnt_nxt = cnt_nxt + CNT_W'(win_nxt[i]);
        end
    end

    assign trip = shift && (cnt_nxt >= CNT_W'(ERR_LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win <= '0;
        end else if (shift) begin
            win <= trip ? '0 : win_nxt;
        end
    end

    // R8: the held count never reaches the limit; reaching it empties the window
    p_cnt_below_limit_r8: assert property (@(posedge clk) disable iff (rst)
        cnt < CNT_W'(ERR_LIMIT));
    // R7: one symbol moves the count by at most one upwards
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (rst)
        (shift && !clr && !trip) |=> (cnt <= $past(cnt) + CNT_W'(1)));
    // R9: no shift, no change
    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clr) |=> $stable(cnt));

endmodule

// File: rtl/rx_bist_monitor.sv
module rx_bist_monitor
    import rx_bist_pkg::*;
#(
    parameter  int WIN_LEN   = 28,
    parameter  int ERR_LIMIT = 14,
    localparam int CNT_W     = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bist_en_i,
    input  logic             sym_vld_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic             prog_o,
    output logic             sync_o,
    output logic [CNT_W-1:0] err_cnt_o
);

    mon_state_e       state, state_nxt;
    logic             prev_mark;
    logic             prog_q;
    logic             sym_mark;
    logic             lock_now;
    logic             track_adv;
    logic             trip;
    logic             at_last;
    logic             loop_end;
    logic [SYM_W-1:0] exp_sym;

    assign sym_mark  = (sym_i == MARK_SYM);
    assign lock_now  = bist_en_i && sym_vld_i && (state == ST_HUNT) && sym_mark && prev_mark;
    assign track_adv = bist_en_i && sym_vld_i && (state == ST_LOCK);
    assign loop_end  = track_adv && at_last && !trip;

    always_comb begin
        state_nxt = state;
        if (!bist_en_i)    state_nxt = ST_HUNT;
        else if (lock_now) state_nxt = ST_LOCK;
        else if (trip)     state_nxt = ST_HUNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            prev_mark <= 1'b0;
            prog_q    <= 1'b0;
        end else begin
            state <= state_nxt;
            if (!bist_en_i || state == ST_LOCK) prev_mark <= 1'b0;
            else if (sym_vld_i)                 prev_mark <= sym_mark;
            prog_q <= bist_en_i && ((state_nxt == ST_HUNT) || loop_end);
        end
    end

    rx_bist_loop_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (lock_now),
        .adv     (track_adv && !trip),
        .exp_sym (exp_sym),
        .at_last (at_last)
    );

    rx_bist_err_window #(
        .WIN_LEN   (WIN_LEN),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_win (
        .clk   (clk),
        .rst   (rst),
        .clr   (!bist_en_i || state == ST_HUNT),
        .shift (track_adv),
        .miss  (sym_i != exp_sym),
        .cnt   (err_cnt_o),
        .trip  (trip)
    );

    assign prog_o = prog_q;
    assign sync_o = (state == ST_LOCK);

    // checker support: high when the previous edge was out of reset
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(bist_en_i)) |-> (!prog_o && !sync_o && err_cnt_o == '0));
    p_hunt_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(bist_en_i) && !sync_o) |-> prog_o);
    p_lock_mark_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_o) |-> $past(bist_en_i && sym_vld_i && sym_i == MARK_SYM));
    p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
        (sync_o && prog_o) |=> (!prog_o || !sync_o));
    p_loss_r8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(sync_o) && $past(bist_en_i)) |-> (prog_o && err_cnt_o == '0));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (sync_o && bist_en_i && !sym_vld_i) |=> (sync_o && $stable(err_cnt_o)));

endmodule

// File: tb/rx_bist_monitor_tb.sv
`timescale 1ns/1ps
module rx_bist_monitor_tb;

    typedef struct {
        logic       prog;
        logic       sync;
        logic [4:0] cnt;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bist_en = 1'b0;
    logic       vld = 1'b0;
    logic [7:0] sym = 8'h00;
    logic       prog_o;
    logic       sync_o;
    logic [4:0] err_cnt_o;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t q[$];
    string cur_req = "R1";

    logic [7:0] pat [511];
    int   sp = 0;
    bit   m_sync = 1'b0;
    bit   m_prev = 1'b0;
    int   m_pos = 0;
    logic [27:0] m_win = '0;

    always #2.5 clk = ~clk;

    rx_bist_monitor u_dut (
        .clk       (clk),
        .rst       (rst),
        .bist_en_i (bist_en),
        .sym_vld_i (vld),
        .sym_i     (sym),
        .prog_o    (prog_o),
        .sync_o    (sync_o),
        .err_cnt_o (err_cnt_o)
    );

    function automatic int ones28(input logic [27:0] w);
        int n = 0;
        for (int i = 0; i < 28; i++) n += int'(w[i]);
        return n;
    endfunction

    // driver: applies one cycle of stimulus and pushes the outcome the requirements predict
    task automatic drive(input bit en, input bit v, input logic [7:0] s);
        exp_t e;
        bit   mis;
        @(negedge clk);
        bist_en = en; vld = v; sym = s;
        if (!en) begin
            m_sync = 0; m_win = '0; m_prev = 0; e.prog = 0;
        end else if (!v) begin
            e.prog = !m_sync;
        end else if (!m_sync) begin
            if (s == 8'hFF && m_prev) begin
                m_sync = 1; m_pos = 1; m_prev = 0;
            end else begin
                m_prev = (s == 8'hFF);
            end
            e.prog = !m_sync;
        end else begin
            mis   = (s != pat[m_pos]);
            m_win = {m_win[26:0], mis};
            if (ones28(m_win) >= 14) begin
                m_sync = 0; m_win = '0; m_prev = 0; e.prog = 1;
            end else begin
                e.prog = (m_pos == 510);
                m_pos  = (m_pos + 1) % 511;
            end
        end
        e.sync = m_sync;
        e.cnt  = 5'(ones28(m_win));
        e.tag  = cur_req;
        q.push_back(e);
    endtask

    task automatic filler(input int n);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 8'((i * 7) % 200 + 3));
    endtask

    task automatic stream(input int n, input int gap, input int err_period, input int err_len);
        logic [7:0] s;
        for (int i = 0; i < n; i++) begin
            if (gap > 0 && (i % gap) == 0) drive(1'b1, 1'b0, 8'hFF);
            s = pat[sp];
            if (err_period > 0 && (i % err_period) < err_len) s = s ^ 8'h5A;
            drive(1'b1, 1'b1, s);
            sp = (sp + 1) % 511;
        end
    endtask

    // monitor: compares each settled output against the queued expectation
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (prog_o !== e.prog || sync_o !== e.sync || err_cnt_o !== e.cnt) begin
                fails++;
                $display("FAIL %s: prog/sync/cnt got %0b/%0b/%0d expected %0b/%0b/%0d",
                         e.tag, prog_o, sync_o, err_cnt_o, e.prog, e.sync, e.cnt);
            end
        end
    end

    initial begin
        logic [8:0] st = 9'h1FF;
        for (int i = 0; i < 511; i++) begin
            pat[i] = st[7:0];
            st = {st[7:0], st[8] ^ st[4]};
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: outputs after reset
        checks++;
        if (prog_o !== 1'b0 || sync_o !== 1'b0 || err_cnt_o !== 5'd0) begin
            fails++;
            $display("FAIL R1: prog/sync/cnt got %0b/%0b/%0d expected 0/0/0", prog_o, sync_o, err_cnt_o);
        end

        cur_req = "R2";
        for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, 8'hFF);
        cur_req = "R3";
        filler(40);
        cur_req = "R4";                    // lone marker symbol must not lock
        drive(1'b1, 1'b1, 8'hFF);
        filler(10);
        stream(512, 0, 0, 0);              // locks on the last symbol (position 0 of loop 2)
        cur_req = "R5";
        stream(500, 0, 0, 0);
        cur_req = "R6";
        stream(30, 0, 0, 0);
        cur_req = "R9";
        stream(600, 3, 0, 0);
        cur_req = "R7";
        stream(300, 0, 28, 6);
        cur_req = "R8";
        stream(60, 0, 60, 20);
        cur_req = "R4";
        stream(1100, 0, 0, 0);
        cur_req = "R2";
        for (int i = 0; i < 5; i++) drive(1'b0, 1'b1, pat[i]);
        cur_req = "R3";
        filler(20);

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule